// File: doc/BRIEF.md
# Boundary-scan test access port with pin sampling

This block is the test access port of a memory die. A serial test clock, a mode-select line and a serial data input walk a sixteen-state controller. That controller picks either a 3-bit instruction register or one of three data registers and shifts it out on a serial data output. The data registers are a 1-bit bypass stage, a 32-bit identification word and a boundary register of `BSR_LEN` cells. The boundary register captures the parallel pin values. There is no dedicated test reset pin. The controller is cleared by the chip's power-on reset, or by holding the mode-select line high for five test clocks.

Two sampling instructions capture the pins in the same way. They differ in one respect: the "sample with outputs off" variant raises a request that tells the memory's data pad drivers to go high impedance. This lets the board read every input without contention. The serial output changes only on the falling test clock edge. It is enabled only while a register is being shifted.

Top module: `bscan_tap`

## Requirements
- R1: After power-on reset the controller is in Test-Logic-Reset, the instruction is 001 (identify), `tdo_oe` and `dq_hiz` are 0, and a first data scan reads the identification word.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state. This reloads instruction 001 and drops `dq_hiz`.
- R3: State transitions follow the standard sixteen-state test controller graph, including the Pause/Exit2 detour inside a data scan, which preserves shifted data.
- R4: In Capture-IR the instruction shift stage loads 3'b001, so the first three bits shifted out, LSB first, are 1, 0, 0.
- R5: Instruction decode: 001 selects the identification register. 000, 010 and 100 select the boundary register. 011, 101, 110 and 111 select the 1-bit bypass register.
- R6: The bypass register captures 0 at Capture-DR, then delays `tdi` by one shift.
- R7: The identification word is bit 0 = 1, bits 11:1 = `ID_MFR`, bits 27:12 = `ID_PART`, bits 31:28 = `ID_REV`. It is shifted out LSB first, and `tdi` follows it in after 32 shifts.
- R8: The boundary register captures `pin_in` at Capture-DR. Cell k appears on the k-th shift, and `tdi` follows after `BSR_LEN` shifts.
- R9: `dq_hiz` is 1 exactly while the active instruction is 000 or 010. It rises only on the edge that leaves Update-IR.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_in | input | BSR_LEN | Pin values captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`; low means high impedance |
| dq_hiz | output | 1 | Request to put the memory data drivers in high impedance |

## Verification
A wrong controller state shows at the ports within one falling edge. `tdo_oe` rises or falls at the wrong time, or the captured prefix of a scan has the wrong length. A misdecoded instruction shows as a scan whose `tdi` echo arrives after the wrong number of shifts, or as a wrong `dq_hiz` level right after Update-IR. Corrupted capture data in any register appears in the first bits of the next scan. An error in the reset path appears one scan after the five-high `tms` sequence.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUNDARY} dr_sel_t;

  localparam logic [IR_W-1:0] OP_IDENT   = 3'b001;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic tap_state_t tap_next(tap_state_t s, logic tms);
    case (s)
      S_TLR:    return tms ? S_TLR    : S_RTI;
      S_RTI:    return tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: return tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: return tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  return tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: return tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: return tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: return tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: return tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: return tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: return tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  return tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: return tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: return tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: return tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: return tms ? S_SEL_DR : S_RTI;
      default:  return S_TLR;
    endcase
  endfunction

  // Which data register an instruction routes between tdi and tdo.
  function automatic dr_sel_t op_route(logic [IR_W-1:0] op);
    case (op)
      3'b001:                 return DR_IDENT;
      3'b000, 3'b010, 3'b100: return DR_BOUNDARY;
      default:                return DR_BYPASS;
    endcase
  endfunction

  // Sampling variant that also turns the memory data drivers off.
  function automatic logic op_outputs_off(logic [IR_W-1:0] op);
    return (op == 3'b000) || (op == 3'b010);
  endfunction

  function automatic logic [ID_W-1:0] make_ident(logic [3:0] rev, logic [15:0] part,
                                                  logic [10:0] mfr);
    return {rev, part, mfr, 1'b1};
  endfunction

endpackage

// File: rtl/bscan_tap_fsm.sv
module bscan_tap_fsm
  import bscan_pkg::*;
(
  input  logic tck,
  input  logic por_n,
  input  logic tms,
  output logic in_tlr,
  output logic cap_ir,
  output logic sh_ir,
  output logic upd_ir,
  output logic cap_dr,
  output logic sh_dr
);

  tap_state_t state;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= S_TLR;
    else        state <= tap_next(state, tms);
  end

  assign in_tlr = (state == S_TLR);
  assign cap_ir = (state == S_CAP_IR);
  assign sh_ir  = (state == S_SH_IR);
  assign upd_ir = (state == S_UPD_IR);
  assign cap_dr = (state == S_CAP_DR);
  assign sh_dr  = (state == S_SH_DR);

  // Run length of consecutive high tms samples, for the reset check.
  logic [2:0] ones_run;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                 ones_run <= 3'd0;
    else if (!tms)              ones_run <= 3'd0;
    else if (ones_run != 3'd7)  ones_run <= ones_run + 3'd1;
  end

  assert_five_ones_reset_R2: assert property (@(posedge tck) disable iff (!por_n)
    (ones_run >= 3'd5) |-> in_tlr);

  assert_shift_exit_R3: assert property (@(posedge tck) disable iff (!por_n)
    (sh_dr && tms) |=> (state == S_EX1_DR));

  assert_pause_holds_R3: assert property (@(posedge tck) disable iff (!por_n)
    ((state == S_PAU_DR) && !tms) |=> (state == S_PAU_DR));

endmodule

// File: rtl/bscan_tap_ir.sv
module bscan_tap_ir
  import bscan_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  logic            in_tlr,
  input  logic            cap_ir,
  input  logic            sh_ir,
  input  logic            upd_ir,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sh <= IR_CAPTURE;
      ir_q  <= OP_IDENT;
    end else begin
      if (cap_ir)     ir_sh <= IR_CAPTURE;
      else if (sh_ir) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      if (in_tlr)      ir_q <= OP_IDENT;
      else if (upd_ir) ir_q <= ir_sh;
    end
  end

  assign ir_lsb = ir_sh[0];

  assert_capture_pattern_R4: assert property (@(posedge tck) disable iff (!por_n)
    cap_ir |=> (ir_sh == IR_CAPTURE));

  assert_reset_ident_R1: assert property (@(posedge tck) disable iff (!por_n)
    in_tlr |=> (ir_q == OP_IDENT));

  assert_ir_holds_R5: assert property (@(posedge tck) disable iff (!por_n)
    (!in_tlr && !upd_ir) |=> $stable(ir_q));

endmodule

// File: rtl/bscan_tap_dr.sv
module bscan_tap_dr
  import bscan_pkg::*;
#(
  parameter int               BSR_LEN = 70,
  parameter logic [ID_W-1:0]  ID_WORD = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tdi,
  input  logic               cap_dr,
  input  logic               sh_dr,
  input  dr_sel_t            sel,
  input  logic [BSR_LEN-1:0] pins,
  output logic               dr_lsb
);

  logic            byp_q;
  logic [ID_W-1:0] id_sh;
  logic [BSR_LEN-1:0] bsr;
  logic [BSR_LEN-1:0] chain_in;

  wire pick_byp = (sel == DR_BYPASS);
  wire pick_id  = (sel == DR_IDENT);
  wire pick_bsr = (sel == DR_BOUNDARY);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                 byp_q <= 1'b0;
    else if (cap_dr && pick_byp) byp_q <= 1'b0;
    else if (sh_dr && pick_byp)  byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                 id_sh <= ID_WORD;
    else if (cap_dr && pick_id)  id_sh <= ID_WORD;
    else if (sh_dr && pick_id)   id_sh <= {tdi, id_sh[ID_W-1:1]};
  end

  for (genvar k = 0; k < BSR_LEN; k++) begin : g_cell
    if (k == BSR_LEN - 1) begin : g_head
      assign chain_in[k] = tdi;
    end else begin : g_link
      assign chain_in[k] = bsr[k+1];
    end
    always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                  bsr[k] <= 1'b0;
      else if (cap_dr && pick_bsr) bsr[k] <= pins[k];
      else if (sh_dr && pick_bsr)  bsr[k] <= chain_in[k];
    end
  end

  always_comb begin
    case (sel)
      DR_IDENT:    dr_lsb = id_sh[0];
      DR_BOUNDARY: dr_lsb = bsr[0];
      default:     dr_lsb = byp_q;
    endcase
  end

  assert_bypass_clear_R6: assert property (@(posedge tck) disable iff (!por_n)
    (cap_dr && pick_byp) |=> (byp_q == 1'b0));

  assert_ident_marker_R7: assert property (@(posedge tck) disable iff (!por_n)
    (cap_dr && pick_id) |=> (id_sh[0] == 1'b1));

  assert_chain_entry_R8: assert property (@(posedge tck) disable iff (!por_n)
    (sh_dr && pick_bsr) |=> (bsr[BSR_LEN-1] == $past(tdi)));

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int          BSR_LEN = 70,
  parameter logic [3:0]  ID_REV  = 4'h0,
  parameter logic [15:0] ID_PART = 16'h4A21,
  parameter logic [10:0] ID_MFR  = 11'h2B5
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               dq_hiz
);

  localparam logic [ID_W-1:0] ID_WORD = make_ident(ID_REV, ID_PART, ID_MFR);

  logic in_tlr, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr;
  logic [IR_W-1:0] ir_q;
  logic ir_lsb, dr_lsb;
  dr_sel_t route;

  bscan_tap_fsm u_fsm (
    .tck, .por_n, .tms,
    .in_tlr, .cap_ir, .sh_ir, .upd_ir, .cap_dr, .sh_dr
  );

  bscan_tap_ir u_ir (
    .tck, .por_n, .tdi,
    .in_tlr, .cap_ir, .sh_ir, .upd_ir,
    .ir_q, .ir_lsb
  );

  assign route  = op_route(ir_q);
  assign dq_hiz = op_outputs_off(ir_q);

  bscan_tap_dr #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_dr (
    .tck, .por_n, .tdi, .cap_dr, .sh_dr,
    .sel(route), .pins(pin_in), .dr_lsb
  );

  // Serial output retimed to the falling edge.
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= sh_ir | sh_dr;
      tdo    <= sh_ir ? ir_lsb : dr_lsb;
    end
  end

  assert_hiz_after_update_R9: assert property (@(posedge tck) disable iff (!por_n)
    $rose(dq_hiz) |-> $past(upd_ir));

  assert_oe_only_in_shift_R10: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (sh_ir || sh_dr));

endmodule

// File: tb/sim_bscan_tap.sv
module sim_bscan_tap;
  localparam int PERIOD = 20;
  localparam int NB = 70;
  localparam logic [31:0] EXP_ID = (32'h0 << 28) | (32'h4A21 << 12) | (32'h2B5 << 1) | 32'h1;

  logic tck = 1'b0;
  logic por_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b1;
  logic [NB-1:0] pins = '0;
  wire tdo, tdo_oe, dq_hiz;

  int n_run = 0, n_fail = 0, edge_err = 0, oe_err = 0;
  bit done = 0;

  bscan_tap u0 (.tck, .por_n, .tms, .tdi, .pin_in(pins), .tdo, .tdo_oe, .dq_hiz);

  always #(PERIOD/2) tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R10: tdo must not move at the rising edge.
  task automatic tick(input logic m, input logic d);
    logic old;
    tms = m; tdi = d;
    @(posedge tck);
    old = tdo;
    #1;
    if (tdo !== old) edge_err++;
    @(negedge tck);
    #1;
  endtask

  task automatic scan_ir(input logic [2:0] code, output logic [2:0] got);
    tick(1, 1); tick(1, 1); tick(0, 1); tick(0, 1);
    for (int i = 0; i < 3; i++) begin
      got[i] = tdo;
      if (tdo_oe !== 1'b1) oe_err++;
      tick(i == 2, code[i]);
    end
    tick(1, 1); tick(0, 1);
  endtask

  task automatic scan_dr(input int len, input logic [127:0] din, input bit detour,
                         output logic [127:0] dout);
    dout = '0;
    tick(1, 1); tick(0, 1); tick(0, 1);
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo;
      if (tdo_oe !== 1'b1) oe_err++;
      if (detour && i == 15) begin
        tick(1, din[i]); tick(0, 1); tick(0, 1); tick(1, 1); tick(0, 1);
      end else begin
        tick(i == len - 1, din[i]);
      end
    end
    tick(1, 1); tick(0, 1);
  endtask

  function automatic logic [127:0] expect_scan(input logic [127:0] cap, input int l,
                                               input logic [127:0] din);
    logic [127:0] e = '0;
    for (int i = 0; i < l + 8; i++) e[i] = (i < l) ? cap[i] : din[i - l];
    return e;
  endfunction

  initial begin : watchdog
    #(PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [2:0] irg;
    logic [127:0] din, dout, cap;
    int l;
    #(PERIOD * 2 + 3);
    chk(tdo_oe === 1'b0, "R1 tdo_oe in reset", 128'(tdo_oe), 128'd0);
    chk(dq_hiz === 1'b0, "R1 dq_hiz in reset", 128'(dq_hiz), 128'd0);
    por_n = 1'b1;
    @(negedge tck); #1;
    tick(0, 1);
    chk(tdo_oe === 1'b0, "R10 tdo_oe idle", 128'(tdo_oe), 128'd0);

    // R1, R3, R7: first scan is the identification word, with a pause detour.
    din = 128'hA5C3;
    scan_dr(40, din, 1'b1, dout);
    cap = 128'(EXP_ID);
    chk(dout[39:0] === expect_scan(cap, 32, din) , "R1 R3 R7 ident scan with pause",
        dout[39:0], expect_scan(cap, 32, din));

    // R4: capture pattern of the instruction register.
    scan_ir(3'b011, irg);
    chk(irg === 3'b001, "R4 capture pattern", 128'(irg), 128'd1);
    chk(tdo_oe === 1'b0, "R10 tdo_oe after scan", 128'(tdo_oe), 128'd0);

    // Sweep every instruction code.
    for (int c = 0; c < 8; c++) begin
      scan_ir(3'(c), irg);
      chk(dq_hiz === ((c == 0) || (c == 2)), "R9 hiz per code", 128'(dq_hiz),
          128'((c == 0) || (c == 2)));
      for (int k = 0; k < NB; k++) pins[k] = (((k * 5) + (c * 3)) % 7) < 3;
      if (c == 1) begin
        l = 32; cap = 128'(EXP_ID);
      end else if (c == 0 || c == 2 || c == 4) begin
        l = NB; cap = 128'(pins);
      end else begin
        l = 1; cap = '0;
      end
      din = {4{32'h6B1D_2E97 ^ 32'(c * 32'h1111)}};
      scan_dr(l + 8, din, 1'b0, dout);
      chk(dout === expect_scan(cap, l, din), "R5 R6 R7 R8 decode and contents",
          dout, expect_scan(cap, l, din));
    end

    // R2: five high tms from Shift-DR while sample-Z is active.
    scan_ir(3'b000, irg);
    chk(dq_hiz === 1'b1, "R9 hiz set", 128'(dq_hiz), 128'd1);
    tick(1, 1); tick(0, 1); tick(0, 1);
    repeat (5) tick(1, 0);
    tick(0, 1);
    chk(dq_hiz === 1'b0, "R2 hiz dropped by reset", 128'(dq_hiz), 128'd0);
    din = 128'h3C;
    scan_dr(40, din, 1'b0, dout);
    cap = 128'(EXP_ID);
    chk(dout[39:0] === expect_scan(cap, 32, din), "R2 ident after tms reset",
        dout[39:0], expect_scan(cap, 32, din));

    chk(edge_err == 0, "R10 tdo stable at rising edge", 128'(edge_err), 128'd0);
    chk(oe_err == 0, "R10 tdo_oe during shift", 128'(oe_err), 128'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule